// File: doc/BRIEF.md
# Load/Store Ordering Queue with Selectable Load Release

This block keeps an eight-slot circular queue of memory operations in program order. A slot is claimed at allocation and learns its kind there. Its address comes later from an address unit. Its data comes later as well: from an execution unit for a store, or from memory for a load. Stores never reach memory early. A store leaves the queue and drives the memory write port only after it reaches the oldest slot, has both address and data, and commit logic retires it.

Loads are released to memory through a load-issue output. A two-bit policy input picks the release rule and may change at any cycle. The strict rule releases only the oldest slot. The middle rule waits until every older store has a known address and none of those addresses equals the load's. The eager rule releases as soon as the load's own address is known. Under the eager rule, a store address that arrives late and matches a younger load that has already issued raises a one-cycle violation flag naming that load. Recovery from the violation is left to the surrounding pipeline.

Top module: `lsq_order_queue`

## Requirements
- R1: Slots are allocated in program order at the next circular index, shown on `alloc_idx` (slot 7 wraps to slot 0). `alloc_ready` is low while all 8 slots are held, and an allocation request in that state is ignored.
- R2: A store writes memory only when it is the oldest slot, has a valid address and valid data, and `retire_en` is high. `mem_wr_valid` then pulses for one cycle, one cycle later, carrying that store's address and data, and the slot is freed.
- R3: `retire_en` is ignored while the oldest slot is incomplete: a load whose data has not returned, or a store lacking address or data. Nothing is written and no slot is freed.
- R4: With `pol_sel` = 2'd0, a load is released only while it occupies the oldest slot.
- R5: With `pol_sel` = 2'd1, a load is released only once every older store in the queue has a valid address.
- R6: With `pol_sel` = 2'd1, a load whose address equals that of an older store with a known address is held until that store leaves the queue.
- R7: With `pol_sel` = 2'd2, a load is released as soon as its own address is valid, even with older stores of unknown address.
- R8: At most one load is released per cycle, the oldest eligible one first. A released load is never released again. `ld_iss_valid` rises one cycle after the load becomes eligible.
- R9: With `pol_sel` = 2'd2, a store address fill that equals the address of a younger load already released pulses `viol_valid` on the next cycle, with `viol_idx` holding the oldest such load.
- R10: After reset the queue is empty (`alloc_ready` = 1, `alloc_idx` = 0), and `ld_iss_valid`, `mem_wr_valid` and `viol_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pol_sel | input | 2 | Load release policy: 0 strict, 1 wait for store addresses, 2 eager |
| alloc_valid | input | 1 | Allocate a slot this cycle |
| alloc_is_store | input | 1 | Kind of the allocated slot: 1 store, 0 load |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | 3 | Slot index the next allocation receives |
| agu_valid | input | 1 | Address fill strobe |
| agu_idx | input | 3 | Slot receiving the address |
| agu_addr | input | 32 | Address value |
| sdata_valid | input | 1 | Store data fill strobe |
| sdata_idx | input | 3 | Store slot receiving data |
| sdata_val | input | 32 | Store data |
| ldret_valid | input | 1 | Load data return strobe |
| ldret_idx | input | 3 | Load slot receiving data |
| ldret_val | input | 32 | Returned load data |
| retire_en | input | 1 | Retire the oldest slot |
| mem_wr_valid | output | 1 | Store write to memory |
| mem_wr_addr | output | 32 | Store write address |
| mem_wr_data | output | 32 | Store write data |
| ld_iss_valid | output | 1 | Load released to memory |
| ld_iss_idx | output | 3 | Slot of the released load |
| ld_iss_addr | output | 32 | Address of the released load |
| viol_valid | output | 1 | Ordering violation detected |
| viol_idx | output | 3 | Slot of the load that issued too early |

## Verification
A lost or extra pointer step shows at once as a wrong `alloc_idx` on the next allocation. A miscounted occupancy surfaces when the queue fills: `alloc_ready` drops after the wrong number of allocations. A stale issued flag appears within a cycle as a repeated or missing `ld_iss_valid`. A wrong age comparison shows up as a load released under a policy that should hold it, or as a violation pointing at the wrong slot. Mistakes in the age ordering therefore reach the ports no more than two cycles after the fill or retire that exposes them.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
  typedef enum logic [1:0] {
    POL_STRICT = 2'd0,
    POL_STADDR = 2'd1,
    POL_EAGER  = 2'd2
  } ld_pol_e;
endpackage

// File: rtl/lsq_ptrs.sv
`timescale 1ns/1ps
module lsq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic            pop,
  output logic [IDXW-1:0] head_q,
  output logic [IDXW-1:0] tail_q,
  output logic [CW-1:0]   cnt_q,
  output logic            full
);
  logic [IDXW-1:0] head_d, tail_d;
  logic [CW-1:0]   cnt_d;
  logic            ptr_en;

  always_comb begin
    head_d = head_q + IDXW'(pop);
    tail_d = tail_q + IDXW'(push);
    cnt_d  = cnt_q + CW'(push) - CW'(pop);
    ptr_en = push | pop;
    full   = (cnt_q == CW'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (ptr_en) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/lsq_entries.sv
`timescale 1ns/1ps
module lsq_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [IDXW-1:0] push_idx,
  input  logic            push_st,
  input  logic            pop,
  input  logic [IDXW-1:0] pop_idx,
  input  logic            addr_we,
  input  logic [IDXW-1:0] addr_idx,
  input  logic [AW-1:0]   addr_in,
  input  logic            sd_we,
  input  logic [IDXW-1:0] sd_idx,
  input  logic [DW-1:0]   sd_in,
  input  logic            lr_we,
  input  logic [IDXW-1:0] lr_idx,
  input  logic [DW-1:0]   lr_in,
  input  logic            iss_we,
  input  logic [IDXW-1:0] iss_idx,
  output logic [DEPTH-1:0] vld_q,
  output logic [DEPTH-1:0] st_q,
  output logic [DEPTH-1:0] av_q,
  output logic [DEPTH-1:0] dv_q,
  output logic [DEPTH-1:0] iss_q,
  output logic [AW-1:0]   addr_q [DEPTH],
  output logic [DW-1:0]   data_q [DEPTH]
);
  logic [DEPTH-1:0] vld_d, st_d, av_d, dv_d, iss_d;
  logic [DEPTH-1:0] a_en, d_en;
  logic [DW-1:0]    data_d [DEPTH];

  always_comb begin
    vld_d = vld_q;
    st_d  = st_q;
    av_d  = av_q;
    dv_d  = dv_q;
    iss_d = iss_q;
    a_en  = '0;
    d_en  = '0;
    for (int i = 0; i < DEPTH; i++) begin
      data_d[i] = data_q[i];
      if (addr_we && addr_idx == IDXW'(i) && vld_q[i]) begin
        av_d[i] = 1'b1;
        a_en[i] = 1'b1;
      end
      if (sd_we && sd_idx == IDXW'(i) && vld_q[i] && st_q[i]) begin
        dv_d[i]   = 1'b1;
        d_en[i]   = 1'b1;
        data_d[i] = sd_in;
      end
      if (lr_we && lr_idx == IDXW'(i) && vld_q[i] && !st_q[i] && iss_q[i]) begin
        dv_d[i]   = 1'b1;
        d_en[i]   = 1'b1;
        data_d[i] = lr_in;
      end
      if (iss_we && iss_idx == IDXW'(i)) iss_d[i] = 1'b1;
      if (pop && pop_idx == IDXW'(i)) vld_d[i] = 1'b0;
      if (push && push_idx == IDXW'(i)) begin
        vld_d[i] = 1'b1;
        st_d[i]  = push_st;
        av_d[i]  = 1'b0;
        dv_d[i]  = 1'b0;
        iss_d[i] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      st_q  <= '0;
      av_q  <= '0;
      dv_q  <= '0;
      iss_q <= '0;
    end else begin
      vld_q <= vld_d;
      st_q  <= st_d;
      av_q  <= av_d;
      dv_q  <= dv_d;
      iss_q <= iss_d;
    end
  end

  // payload storage carries no reset; written only under its enables
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (a_en[i]) addr_q[i] <= addr_in;
      if (d_en[i]) data_q[i] <= data_d[i];
    end
  end
endmodule

// File: rtl/lsq_load_pick.sv
`timescale 1ns/1ps
module lsq_load_pick
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [1:0]       pol,
  input  logic [IDXW-1:0]  head,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] st,
  input  logic [DEPTH-1:0] av,
  input  logic [DEPTH-1:0] iss,
  input  logic [AW-1:0]    addr [DEPTH],
  output logic             pick_v,
  output logic [IDXW-1:0]  pick_idx
);
  logic [IDXW-1:0]  age [DEPTH];
  logic [DEPTH-1:0] unk, hit, base, elig;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) age[i] = IDXW'(i) - head;
  end

  // per-load scan of older stores: unknown address (R5) or same address (R6)
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      unk[i] = 1'b0;
      hit[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j != i && vld[j] && st[j] && age[j] < age[i]) begin
          if (!av[j]) unk[i] = 1'b1;
          else if (addr[j] == addr[i]) hit[i] = 1'b1;
        end
      end
      base[i] = vld[i] && !st[i] && av[i] && !iss[i];
      case (pol)
        POL_STADDR: elig[i] = base[i] && !unk[i] && !hit[i];
        POL_EAGER:  elig[i] = base[i];
        default:    elig[i] = base[i] && (age[i] == '0);
      endcase
    end
  end

  // oldest eligible load wins (R8)
  always_comb begin
    pick_v   = 1'b0;
    pick_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!pick_v && elig[head + IDXW'(k)]) begin
        pick_v   = 1'b1;
        pick_idx = head + IDXW'(k);
      end
    end
  end
endmodule

// File: rtl/lsq_viol_detect.sv
`timescale 1ns/1ps
module lsq_viol_detect
  import lsq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int IDXW = $clog2(DEPTH)
) (
  input  logic [1:0]       pol,
  input  logic [IDXW-1:0]  head,
  input  logic             fill_we,
  input  logic [IDXW-1:0]  fill_idx,
  input  logic [AW-1:0]    fill_addr,
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] st,
  input  logic [DEPTH-1:0] av,
  input  logic [DEPTH-1:0] iss_eff,
  input  logic [AW-1:0]    addr [DEPTH],
  output logic             hit,
  output logic [IDXW-1:0]  hit_idx
);
  logic [IDXW-1:0] st_age;
  logic            armed;
  logic [IDXW-1:0] j;

  always_comb begin
    st_age  = fill_idx - head;
    armed   = (pol == POL_EAGER) && fill_we && vld[fill_idx] && st[fill_idx];
    hit     = 1'b0;
    hit_idx = '0;
    j       = '0;
    for (int k = 0; k < DEPTH; k++) begin
      j = head + IDXW'(k);
      if (armed && !hit && IDXW'(k) > st_age && vld[j] && !st[j] &&
          av[j] && iss_eff[j] && addr[j] == fill_addr) begin
        hit     = 1'b1;
        hit_idx = j;
      end
    end
  end
endmodule

// File: rtl/lsq_order_queue.sv
`timescale 1ns/1ps
module lsq_order_queue #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = IDXW + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      pol_sel,
  input  logic            alloc_valid,
  input  logic            alloc_is_store,
  output logic            alloc_ready,
  output logic [IDXW-1:0] alloc_idx,
  input  logic            agu_valid,
  input  logic [IDXW-1:0] agu_idx,
  input  logic [AW-1:0]   agu_addr,
  input  logic            sdata_valid,
  input  logic [IDXW-1:0] sdata_idx,
  input  logic [DW-1:0]   sdata_val,
  input  logic            ldret_valid,
  input  logic [IDXW-1:0] ldret_idx,
  input  logic [DW-1:0]   ldret_val,
  input  logic            retire_en,
  output logic            mem_wr_valid,
  output logic [AW-1:0]   mem_wr_addr,
  output logic [DW-1:0]   mem_wr_data,
  output logic            ld_iss_valid,
  output logic [IDXW-1:0] ld_iss_idx,
  output logic [AW-1:0]   ld_iss_addr,
  output logic            viol_valid,
  output logic [IDXW-1:0] viol_idx
);
  logic [IDXW-1:0]  head_q, tail_q;
  logic [CW-1:0]    cnt_q;
  logic             full, push, pop, head_rdy;
  logic [DEPTH-1:0] vld_q, st_q, av_q, dv_q, iss_q, iss_eff;
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic             pick_v, vhit;
  logic [IDXW-1:0]  pick_idx, vhit_idx;

  logic            wr_v_d, iss_v_d, viol_v_d;
  logic            wr_en, iss_en, viol_en;

  // R1 allocation, R2/R3 retirement gate
  always_comb begin
    alloc_ready = !full;
    alloc_idx   = tail_q;
    push        = alloc_valid && !full;
    head_rdy    = vld_q[head_q] &&
                  (st_q[head_q] ? (av_q[head_q] && dv_q[head_q]) : dv_q[head_q]);
    pop         = retire_en && head_rdy;
  end

  lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .head_q(head_q), .tail_q(tail_q), .cnt_q(cnt_q), .full(full)
  );

  lsq_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ent (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_idx(tail_q), .push_st(alloc_is_store),
    .pop(pop), .pop_idx(head_q),
    .addr_we(agu_valid), .addr_idx(agu_idx), .addr_in(agu_addr),
    .sd_we(sdata_valid), .sd_idx(sdata_idx), .sd_in(sdata_val),
    .lr_we(ldret_valid), .lr_idx(ldret_idx), .lr_in(ldret_val),
    .iss_we(pick_v), .iss_idx(pick_idx),
    .vld_q(vld_q), .st_q(st_q), .av_q(av_q), .dv_q(dv_q), .iss_q(iss_q),
    .addr_q(addr_q), .data_q(data_q)
  );

  lsq_load_pick #(.DEPTH(DEPTH), .AW(AW)) u_pick (
    .pol(pol_sel), .head(head_q), .vld(vld_q), .st(st_q), .av(av_q),
    .iss(iss_q), .addr(addr_q), .pick_v(pick_v), .pick_idx(pick_idx)
  );

  // a load picked this very cycle counts as already released
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      iss_eff[i] = iss_q[i] || (pick_v && pick_idx == IDXW'(i));
  end

  lsq_viol_detect #(.DEPTH(DEPTH), .AW(AW)) u_viol (
    .pol(pol_sel), .head(head_q), .fill_we(agu_valid), .fill_idx(agu_idx),
    .fill_addr(agu_addr), .vld(vld_q), .st(st_q), .av(av_q),
    .iss_eff(iss_eff), .addr(addr_q), .hit(vhit), .hit_idx(vhit_idx)
  );

  // output register next-state
  always_comb begin
    wr_v_d   = pop && st_q[head_q];
    iss_v_d  = pick_v;
    viol_v_d = vhit;
    wr_en    = wr_v_d || mem_wr_valid;
    iss_en   = iss_v_d || ld_iss_valid;
    viol_en  = viol_v_d || viol_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_wr_valid <= 1'b0;
      ld_iss_valid <= 1'b0;
      viol_valid   <= 1'b0;
    end else begin
      if (wr_en)   mem_wr_valid <= wr_v_d;
      if (iss_en)  ld_iss_valid <= iss_v_d;
      if (viol_en) viol_valid   <= viol_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_v_d) begin
      mem_wr_addr <= addr_q[head_q];
      mem_wr_data <= data_q[head_q];
    end
    if (iss_v_d) begin
      ld_iss_idx  <= pick_idx;
      ld_iss_addr <= addr_q[pick_idx];
    end
    if (viol_v_d) viol_idx <= vhit_idx;
  end
endmodule

// File: rtl/lsq_order_queue_chk.sv
`timescale 1ns/1ps
module lsq_order_queue_chk #(
  parameter int DEPTH = 8,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CW   = IDXW + 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      pol_sel,
  input logic            retire_en,
  input logic            agu_valid,
  input logic            mem_wr_valid,
  input logic            ld_iss_valid,
  input logic [IDXW-1:0] ld_iss_idx,
  input logic            viol_valid,
  input logic [IDXW-1:0] head_q,
  input logic [CW-1:0]   cnt_q
);
  a_r1_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r2_write_needs_retire: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> $past(retire_en));

  a_r4_strict_from_head: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_iss_valid && $past(pol_sel) == 2'd0) |-> (ld_iss_idx == $past(head_q)));

  a_r8_no_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_iss_valid && $past(ld_iss_valid)) |-> (ld_iss_idx != $past(ld_iss_idx)));

  a_r9_viol_from_eager_fill: assert property (@(posedge clk) disable iff (!rst_n)
    viol_valid |-> ($past(agu_valid) && $past(pol_sel) == 2'd2));
endmodule

bind lsq_order_queue lsq_order_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .retire_en(retire_en),
  .agu_valid(agu_valid), .mem_wr_valid(mem_wr_valid),
  .ld_iss_valid(ld_iss_valid), .ld_iss_idx(ld_iss_idx),
  .viol_valid(viol_valid), .head_q(head_q), .cnt_q(cnt_q)
);

// File: tb/tb_lsq_order_queue.sv
`timescale 1ns/1ps
module tb_lsq_order_queue;
  localparam int OP_NOP = 0, OP_ALD = 1, OP_AST = 2, OP_ADR = 3,
                 OP_SDT = 4, OP_LRT = 5, OP_RET = 6, OP_POL = 7;

  typedef struct packed {
    logic [2:0]  op;
    logic [2:0]  idx;
    logic [31:0] val;
    logic [2:0]  aidx;
    logic [1:0]  niss;
    logic [2:0]  iidx;
    logic        nwr;
    logic [31:0] waddr;
    logic        nviol;
    logic [2:0]  vidx;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 53;
  localparam vec_t VECS [NV] = '{
    // strict policy (R4), in-order store write (R2), early retire ignored (R3)
    '{3'd7,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd4},
    '{3'd2,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd1,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd3,3'd1,32'h100,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd4},
    '{3'd3,3'd0,32'h200,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd4},
    '{3'd4,3'd0,32'hAAAA,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd1,3'd1,1'b1,32'h200,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd3},
    '{3'd5,3'd1,32'h55,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd3},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd3},
    // wait-for-store-address policy (R5, R6)
    '{3'd7,3'd0,32'd1,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd5},
    '{3'd2,3'd0,32'd0,3'd2,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd3,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd3,3'd3,32'h300,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd5},
    '{3'd3,3'd2,32'h400,3'd0,2'd1,3'd3,1'b0,32'h0,1'b0,3'd0,4'd5},
    '{3'd2,3'd0,32'd0,3'd4,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd5,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd3,3'd4,32'h500,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd6},
    '{3'd3,3'd5,32'h500,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd6},
    '{3'd4,3'd2,32'h1,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b1,32'h400,1'b0,3'd0,4'd6},
    '{3'd5,3'd3,32'h66,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd4,3'd4,32'h2,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd1,3'd5,1'b1,32'h500,1'b0,3'd0,4'd6},
    '{3'd5,3'd5,32'h77,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    // eager policy across the wrap (R7, R9)
    '{3'd7,3'd0,32'd2,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd7},
    '{3'd2,3'd0,32'd0,3'd6,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd7,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd3,3'd0,32'h600,3'd0,2'd1,3'd0,1'b0,32'h0,1'b0,3'd0,4'd7},
    '{3'd3,3'd7,32'h700,3'd0,2'd1,3'd7,1'b0,32'h0,1'b0,3'd0,4'd7},
    '{3'd3,3'd6,32'h600,3'd0,2'd0,3'd0,1'b0,32'h0,1'b1,3'd0,4'd9},
    '{3'd4,3'd6,32'h3,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b1,32'h600,1'b0,3'd0,4'd2},
    '{3'd5,3'd7,32'h88,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd5,3'd0,32'h99,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    // two loads freed together, oldest first (R8)
    '{3'd7,3'd0,32'd1,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd8},
    '{3'd2,3'd0,32'd0,3'd1,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd2,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd1,3'd0,32'd0,3'd3,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1},
    '{3'd3,3'd3,32'h10,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd5},
    '{3'd3,3'd2,32'h20,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd5},
    '{3'd3,3'd1,32'h30,3'd0,2'd2,3'd2,1'b0,32'h0,1'b0,3'd0,4'd8},
    '{3'd4,3'd1,32'h4,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b1,32'h30,1'b0,3'd0,4'd2},
    '{3'd5,3'd2,32'h11,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd5,3'd3,32'h12,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2},
    '{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2}
  };

  logic        clk, rst_n;
  logic [1:0]  pol_sel;
  logic        alloc_valid, alloc_is_store, alloc_ready;
  logic [2:0]  alloc_idx;
  logic        agu_valid;
  logic [2:0]  agu_idx;
  logic [31:0] agu_addr;
  logic        sdata_valid;
  logic [2:0]  sdata_idx;
  logic [31:0] sdata_val;
  logic        ldret_valid;
  logic [2:0]  ldret_idx;
  logic [31:0] ldret_val;
  logic        retire_en;
  logic        mem_wr_valid, ld_iss_valid, viol_valid;
  logic [31:0] mem_wr_addr, mem_wr_data, ld_iss_addr;
  logic [2:0]  ld_iss_idx, viol_idx;

  int n_run, n_fail;
  bit done;
  int s_niss, s_nwr, s_nviol;
  logic [2:0]  s_iidx, s_vidx;
  logic [31:0] s_waddr, s_wdata;

  lsq_order_queue dut (
    .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel),
    .alloc_valid(alloc_valid), .alloc_is_store(alloc_is_store),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .agu_valid(agu_valid), .agu_idx(agu_idx), .agu_addr(agu_addr),
    .sdata_valid(sdata_valid), .sdata_idx(sdata_idx), .sdata_val(sdata_val),
    .ldret_valid(ldret_valid), .ldret_idx(ldret_idx), .ldret_val(ldret_val),
    .retire_en(retire_en),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .ld_iss_valid(ld_iss_valid), .ld_iss_idx(ld_iss_idx), .ld_iss_addr(ld_iss_addr),
    .viol_valid(viol_valid), .viol_idx(viol_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input int req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 1'b0; alloc_is_store = 1'b0;
    agu_valid = 1'b0; sdata_valid = 1'b0; ldret_valid = 1'b0; retire_en = 1'b0;
  endtask

  task automatic sample();
    if (ld_iss_valid) begin
      if (s_niss == 0) s_iidx = ld_iss_idx;
      s_niss++;
    end
    if (mem_wr_valid) begin
      s_nwr++; s_waddr = mem_wr_addr; s_wdata = mem_wr_data;
    end
    if (viol_valid) begin
      s_nviol++; s_vidx = viol_idx;
    end
  endtask

  // one operation, then a three-cycle observation window
  task automatic step(input vec_t v);
    @(negedge clk);
    s_niss = 0; s_nwr = 0; s_nviol = 0;
    case (int'(v.op))
      OP_ALD, OP_AST: begin
        alloc_valid = 1'b1; alloc_is_store = (int'(v.op) == OP_AST);
        chk(alloc_idx == v.aidx, 1, "alloc_idx", alloc_idx, v.aidx);
      end
      OP_ADR: begin agu_valid = 1'b1; agu_idx = v.idx; agu_addr = v.val; end
      OP_SDT: begin sdata_valid = 1'b1; sdata_idx = v.idx; sdata_val = v.val; end
      OP_LRT: begin ldret_valid = 1'b1; ldret_idx = v.idx; ldret_val = v.val; end
      OP_RET: retire_en = 1'b1;
      OP_POL: pol_sel = v.val[1:0];
      default: ;
    endcase
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); @(negedge clk);
      if (c == 0) idle_inputs();
      sample();
    end
    chk(s_niss == int'(v.niss), int'(v.req), "load issues", s_niss, v.niss);
    if (v.niss != 0) chk(s_iidx == v.iidx, int'(v.req), "first issued slot", s_iidx, v.iidx);
    chk(s_nwr == int'(v.nwr), int'(v.req), "store writes", s_nwr, v.nwr);
    if (v.nwr) chk(s_waddr == v.waddr, int'(v.req), "write address", s_waddr, v.waddr);
    chk(s_nviol == int'(v.nviol), int'(v.req), "violations", s_nviol, v.nviol);
    if (v.nviol) chk(s_vidx == v.vidx, int'(v.req), "violation slot", s_vidx, v.vidx);
  endtask

  initial begin
    n_run = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; pol_sel = 2'd0;
    agu_idx = '0; agu_addr = '0; sdata_idx = '0; sdata_val = '0;
    ldret_idx = '0; ldret_val = '0;
    idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(alloc_ready == 1'b1, 10, "alloc_ready", alloc_ready, 1);
    chk(alloc_idx == 3'd0, 10, "alloc_idx", alloc_idx, 0);
    chk(!ld_iss_valid && !mem_wr_valid && !viol_valid, 10, "output strobes",
        {ld_iss_valid, mem_wr_valid, viol_valid}, 0);

    for (int s = 0; s < NV; s++) step(VECS[s]);

    // R1: fill all eight slots from slot 4 around the wrap
    for (int k = 0; k < 8; k++)
      step('{3'd2,3'd0,32'd0,3'((4 + k) % 8),2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd1});
    @(negedge clk);
    chk(alloc_ready == 1'b0, 1, "alloc_ready when full", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_is_store = 1'b1;
    @(posedge clk); @(negedge clk); idle_inputs();
    chk(alloc_ready == 1'b0, 1, "alloc_ready after refused alloc", alloc_ready, 0);
    // R3: head store lacks address and data, retire must be ignored
    step('{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd3});
    chk(alloc_ready == 1'b0, 3, "queue still full", alloc_ready, 0);
    step('{3'd3,3'd4,32'h900,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2});
    step('{3'd4,3'd4,32'hBEEF,3'd0,2'd0,3'd0,1'b0,32'h0,1'b0,3'd0,4'd2});
    // R2: retire now writes address and data
    step('{3'd6,3'd0,32'd0,3'd0,2'd0,3'd0,1'b1,32'h900,1'b0,3'd0,4'd2});
    chk(s_wdata == 32'hBEEF, 2, "write data", s_wdata, 32'hBEEF);
    chk(alloc_ready == 1'b1, 1, "slot freed", alloc_ready, 1);
    chk(alloc_idx == 3'd4, 1, "freed slot index", alloc_idx, 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule